// File: doc/BRIEF.md
# Buck Converter Start-Up and Hiccup Sequencer

This block orders the life of a synchronous step-down controller, from power-up to steady regulation and through overload recovery. It holds everything off until a supply-good flag and an enable flag are both true. It then waits a fixed settling time and starts an external overcurrent set-point sampler. After the sampler reports completion, the block ramps a 6-bit reference code from zero to full scale in equal timed steps. Switching is allowed only while that ramp runs or after it completes.

An overcurrent trip during the ramp or in steady operation removes switching in the same cycle. The block then waits out two dummy ramp periods with the gates off and starts a fresh real ramp. The retry path never samples the set point again. Only a disable followed by a re-enable, or a loss of supply-good, leads back through the settling delay and a new sample. All durations are counted in system-clock cycles and set by parameters, so they do not depend on the switching frequency.

Top module: `buck_start_seq`

## Requirements
- R1: While `rst_n` or `supply_ok` is low, the block is held in the off state asynchronously, with no clock edge needed. In the off state `state_o` is 0 and `ref_code`, `sw_en`, `sample_start` and `ss_done` are all 0.
- R2: In the off state with `en_ok` high, the block moves to the delay state (`state_o` = 1) at the next clock edge. In any state, `en_ok` sampled low returns the block to the off state at the next edge, and `sw_en` is 0 from then on.
- R3: The delay state lasts exactly `DELAY_CYC` cycles and is followed by the sampling state (`state_o` = 2). `sample_start` is high for exactly one cycle, the first cycle of the sampling state.
- R4: The sampling state lasts until `sample_done` is sampled high, whatever its duration. At the following edge the block enters the ramp state (`state_o` = 3) with `ref_code` = 0.
- R5: In the ramp state `ref_code` rises by one every `STEP_CYC` cycles. After 63 increments, which is `63*STEP_CYC` cycles after entry, the block enters the run state (`state_o` = 4). In the run state `ref_code` is 63 and `ss_done` is 1 until the next fault or disable.
- R6: `sw_en` is high only in the ramp and run states. An asserted `ocp_trip` forces `sw_en` low in the same cycle, without waiting for a clock edge.
- R7: `ocp_trip` sampled high in the ramp or run state moves the block to the hiccup state (`state_o` = 5) at the next edge, with `ref_code` and `ss_done` at 0. This holds even on the cycle where the ramp would have completed. The hiccup state lasts `2*64*STEP_CYC` cycles (two dummy ramp periods), then a real ramp restarts from code 0.
- R8: `ocp_trip` has no effect in the off, delay, sampling and hiccup states, and a retry never asserts `sample_start`.
- R9: A disable and re-enable, or a loss and return of supply-good, runs the full settling delay and asserts `sample_start` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Bias supply above its power-on threshold; low acts as an asynchronous reset |
| en_ok | input | 1 | Enable line qualified above its trip level |
| sample_done | input | 1 | Set-point sampler has captured its value |
| ocp_trip | input | 1 | Overcurrent comparator fired |
| ref_code | output | CODE_W | Soft-start reference code for the reference DAC |
| sw_en | output | 1 | Allows the modulator and gate drivers to switch |
| sample_start | output | 1 | One-cycle start strobe to the set-point sampler |
| state_o | output | 3 | Sequencer state: 0 off, 1 delay, 2 sample, 3 ramp, 4 run, 5 hiccup |
| ss_done | output | 1 | Ramp has reached full scale |

## Verification
The sharpest collision is an overcurrent trip that lands on the very cycle in which the last ramp step would carry the machine into the run state. The bench drives the trip in the cycle just before the final step boundary. It expects the hiccup state, not the run state, with the ramp state having lasted exactly `63*STEP_CYC` cycles. A second collision is a trip that arrives while hiccup timing is already in progress. That trip must neither restart nor shorten the two dummy periods, which the scoreboard judges from the exact length of the hiccup state.

// File: rtl/bss_pkg.sv
package bss_pkg;

   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_DELAY  = 3'd1,
      ST_SAMPLE = 3'd2,
      ST_RAMP   = 3'd3,
      ST_RUN    = 3'd4,
      ST_DUMMY  = 3'd5
   } bss_state_e;

endpackage

// File: rtl/bss_tick.sv
module bss_tick #(
   parameter int unsigned N = 4
) (
   input  logic clk,
   input  logic arst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);
   localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;

   generate
      if (N < 2) begin : g_bad_n
         $error("bss_tick: N must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign tick = run && (cnt_q == CW'(N - 1));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)       cnt_q <= '0;
      else if (clr)      cnt_q <= '0;
      else if (run)      cnt_q <= tick ? '0 : cnt_q + CW'(1);
   end

endmodule

// File: rtl/bss_stepper.sv
module bss_stepper #(
   parameter int unsigned W = 7
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   generate
      if (W < 2) begin : g_bad_w
         $error("bss_stepper: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)    cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (inc)   cnt <= cnt + W'(1);
   end

endmodule

// File: rtl/bss_fsm.sv
module bss_fsm
   import bss_pkg::*;
#(
   parameter int unsigned SW          = 7,
   parameter int unsigned LEVELS      = 64,
   parameter int unsigned DUMMY_STEPS = 128
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          en_ok,
   input  logic          sample_done,
   input  logic          ocp_trip,
   input  logic          dly_tick,
   input  logic          stp_tick,
   input  logic [SW-1:0] step_cnt,
   output bss_state_e    st_q,
   output logic          tmr_clr,
   output logic          dly_run,
   output logic          stp_run,
   output logic          step_clr,
   output logic          step_inc,
   output logic          samp_start_q
);
   localparam logic [SW-1:0] LAST_RAMP  = SW'(LEVELS - 2);
   localparam logic [SW-1:0] LAST_DUMMY = SW'(DUMMY_STEPS - 1);

   bss_state_e st_d;

   always_comb begin
      st_d = st_q;
      if (!en_ok) begin
         st_d = ST_OFF;
      end else begin
         unique case (st_q)
            ST_OFF:    st_d = ST_DELAY;
            ST_DELAY:  if (dly_tick) st_d = ST_SAMPLE;
            ST_SAMPLE: if (sample_done) st_d = ST_RAMP;
            ST_RAMP: begin
               if (ocp_trip)                              st_d = ST_DUMMY;
               else if (stp_tick && step_cnt == LAST_RAMP) st_d = ST_RUN;
            end
            ST_RUN:    if (ocp_trip) st_d = ST_DUMMY;
            ST_DUMMY:  if (stp_tick && step_cnt == LAST_DUMMY) st_d = ST_RAMP;
            default:   st_d = ST_OFF;
         endcase
      end
   end

   assign tmr_clr  = (st_d != st_q);
   assign dly_run  = (st_q == ST_DELAY);
   assign stp_run  = (st_q == ST_RAMP) || (st_q == ST_DUMMY);
   assign step_clr = (st_d != st_q) && (st_d != ST_RUN);
   assign step_inc = stp_tick && stp_run;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st_q         <= ST_OFF;
         samp_start_q <= 1'b0;
      end else begin
         st_q         <= st_d;
         samp_start_q <= (st_d == ST_SAMPLE) && (st_q != ST_SAMPLE);
      end
   end

   // R2: a low enable always lands in the off state
   a_r2_disable_to_off: assert property (@(posedge clk) disable iff (!arst_n)
      !en_ok |=> (st_q == ST_OFF));

   // R3: the sampler strobe is a single-cycle pulse
   a_r3_strobe_single: assert property (@(posedge clk) disable iff (!arst_n)
      samp_start_q |=> !samp_start_q);

   // R4: sampling waits for the done indication
   a_r4_wait_done: assert property (@(posedge clk) disable iff (!arst_n)
      (st_q == ST_SAMPLE && en_ok && !sample_done) |=> (st_q == ST_SAMPLE));

   // R5: the ramp code never jumps by more than one step
   a_r5_step_by_one: assert property (@(posedge clk) disable iff (!arst_n)
      (st_q == ST_RAMP) |=> (st_q != ST_RAMP || step_cnt == $past(step_cnt)
                             || step_cnt == $past(step_cnt) + SW'(1)));

   // R7: a trip while switching always enters hiccup
   a_r7_trip_hiccup: assert property (@(posedge clk) disable iff (!arst_n)
      ((st_q == ST_RAMP || st_q == ST_RUN) && ocp_trip && en_ok) |=> (st_q == ST_DUMMY));

   // R8: hiccup never re-requests a set-point sample
   a_r8_no_resample: assert property (@(posedge clk) disable iff (!arst_n)
      (st_q == ST_DUMMY) |-> !samp_start_q);

endmodule

// File: rtl/buck_start_seq.sv
module buck_start_seq
   import bss_pkg::*;
#(
   parameter int unsigned DELAY_CYC     = 68000,
   parameter int unsigned STEP_CYC      = 1063,
   parameter int unsigned CODE_W        = 6,
   parameter int unsigned DUMMY_PERIODS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   input  logic              en_ok,
   input  logic              sample_done,
   input  logic              ocp_trip,
   output logic [CODE_W-1:0] ref_code,
   output logic              sw_en,
   output logic              sample_start,
   output logic [2:0]        state_o,
   output logic              ss_done
);
   localparam int unsigned LEVELS      = 1 << CODE_W;
   localparam int unsigned DUMMY_STEPS = DUMMY_PERIODS * LEVELS;
   localparam int unsigned SW          = $clog2(DUMMY_STEPS);

   generate
      if (CODE_W < 2 || CODE_W > 12) begin : g_bad_code
         $error("buck_start_seq: CODE_W out of range");
      end
      if (DUMMY_PERIODS < 1) begin : g_bad_dummy
         $error("buck_start_seq: DUMMY_PERIODS must be at least 1");
      end
   endgenerate

   logic          arst_n;
   logic          dly_tick, stp_tick;
   logic          tmr_clr, dly_run, stp_run, step_clr, step_inc;
   logic [SW-1:0] step_cnt;
   bss_state_e    st_q;

   assign arst_n = rst_n & supply_ok;

   bss_tick #(.N(DELAY_CYC)) i_dly_tick (
      .clk(clk), .arst_n(arst_n), .clr(tmr_clr), .run(dly_run), .tick(dly_tick));

   bss_tick #(.N(STEP_CYC)) i_stp_tick (
      .clk(clk), .arst_n(arst_n), .clr(tmr_clr), .run(stp_run), .tick(stp_tick));

   bss_stepper #(.W(SW)) i_stepper (
      .clk(clk), .arst_n(arst_n), .clr(step_clr), .inc(step_inc), .cnt(step_cnt));

   bss_fsm #(.SW(SW), .LEVELS(LEVELS), .DUMMY_STEPS(DUMMY_STEPS)) i_fsm (
      .clk(clk), .arst_n(arst_n), .en_ok(en_ok), .sample_done(sample_done),
      .ocp_trip(ocp_trip), .dly_tick(dly_tick), .stp_tick(stp_tick),
      .step_cnt(step_cnt), .st_q(st_q), .tmr_clr(tmr_clr), .dly_run(dly_run),
      .stp_run(stp_run), .step_clr(step_clr), .step_inc(step_inc),
      .samp_start_q(sample_start));

   logic switching;
   assign switching = (st_q == ST_RAMP) || (st_q == ST_RUN);
   assign ref_code  = switching ? step_cnt[CODE_W-1:0] : '0;
   assign sw_en     = switching && !ocp_trip;
   assign ss_done   = (st_q == ST_RUN);
   assign state_o   = st_q;

endmodule

// File: tb/test_buck_start_seq.sv
module test_buck_start_seq;
   localparam int DLY = 20;
   localparam int STP = 3;
   localparam int RAMP_LEN  = 63 * STP;
   localparam int DUMMY_LEN = 128 * STP;

   logic clk = 1'b0;
   logic rst_n = 1'b0, supply_ok = 1'b0, en_ok = 1'b0;
   logic sample_done = 1'b0, ocp_trip = 1'b0;
   logic [5:0] ref_code;
   logic sw_en, sample_start, ss_done;
   logic [2:0] state_o;

   always #10 clk = ~clk;

   buck_start_seq #(.DELAY_CYC(DLY), .STEP_CYC(STP), .CODE_W(6), .DUMMY_PERIODS(2))
   i_buck_start_seq (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_ok(en_ok),
      .sample_done(sample_done), .ocp_trip(ocp_trip), .ref_code(ref_code),
      .sw_en(sw_en), .sample_start(sample_start), .state_o(state_o), .ss_done(ss_done));

   typedef struct {
      int    st;
      int    dur;
      string tag;
   } exp_t;

   exp_t q[$];
   int total = 0, fails = 0, cyc = 0, last = 0, n_samp = 0;
   logic [2:0] prev = 3'd0;
   bit mon_on = 1'b0, ended = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push(input int st, input int dur, input string tag);
      exp_t e;
      e.st = st; e.dur = dur; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   always @(posedge clk) cyc++;

   // monitor: pops one expected state entry per observed transition
   always @(negedge clk) begin
      if (mon_on) begin
         if (state_o != prev) begin
            if (q.size() == 0) begin
               chk("R2 unexpected transition", int'(state_o), 99);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk({e.tag, " state"}, int'(state_o), e.st);
               if (e.dur >= 0) chk({e.tag, " duration"}, cyc - last, e.dur);
            end
            prev = state_o;
            last = cyc;
         end
         if (sample_start) n_samp++;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset state", int'(state_o), 0);
      chk("R1 reset ref", int'(ref_code), 0);
      chk("R1 reset sw_en", int'(sw_en), 0);
      chk("R1 reset strobe", int'(sample_start), 0);
      chk("R1 reset ss_done", int'(ss_done), 0);
      rst_n = 1'b1; supply_ok = 1'b1; mon_on = 1'b1;
      repeat (4) @(negedge clk);
      chk("R2 stays off without enable", int'(state_o), 0);

      // first start-up; a trip during the delay must be ignored (R8)
      push(1, -1, "R2"); push(2, DLY, "R3"); push(3, 6, "R4"); push(4, RAMP_LEN, "R5");
      en_ok = 1'b1; ocp_trip = 1'b1;
      do @(negedge clk); while (!sample_start);
      ocp_trip = 1'b0;
      chk("R3 sampling state", int'(state_o), 2);
      @(negedge clk);
      chk("R3 strobe one cycle", int'(sample_start), 0);
      repeat (4) @(negedge clk);
      sample_done = 1'b1;
      @(negedge clk);
      sample_done = 1'b0;
      chk("R6 sw_en in ramp", int'(sw_en), 1);
      for (int k = 0; k < 63; k++) begin
         chk("R5 ramp code", int'(ref_code), k);
         repeat (STP) @(negedge clk);
      end
      chk("R5 run state", int'(state_o), 4);
      chk("R5 full code", int'(ref_code), 63);
      chk("R5 ss_done", int'(ss_done), 1);

      // trip in run; a second trip inside hiccup is ignored
      push(5, -1, "R7"); push(3, DUMMY_LEN, "R7 R8");
      repeat (2) @(negedge clk);
      ocp_trip = 1'b1;
      #1 chk("R6 same-cycle gate", int'(sw_en), 0);
      @(negedge clk);
      ocp_trip = 1'b0;
      chk("R7 hiccup state", int'(state_o), 5);
      chk("R7 hiccup ref", int'(ref_code), 0);
      chk("R7 hiccup ss_done", int'(ss_done), 0);
      repeat (100) @(negedge clk);
      ocp_trip = 1'b1;
      @(negedge clk);
      ocp_trip = 1'b0;
      chk("R8 ignored in hiccup", int'(sw_en), 0);
      do @(negedge clk); while (state_o != 3);

      // trip on the cycle of the final ramp step: trip wins
      repeat (RAMP_LEN - 1) @(negedge clk);
      chk("R5 last level before end", int'(ref_code), 62);
      push(5, RAMP_LEN, "R7 collision"); push(3, DUMMY_LEN, "R7"); push(4, RAMP_LEN, "R5");
      ocp_trip = 1'b1;
      @(negedge clk);
      ocp_trip = 1'b0;
      do @(negedge clk); while (state_o != 4);
      chk("R8 no resample on retry", n_samp, 1);

      // disable and re-enable
      push(0, -1, "R2");
      en_ok = 1'b0;
      @(negedge clk);
      chk("R2 disabled state", int'(state_o), 0);
      chk("R2 disabled sw_en", int'(sw_en), 0);
      repeat (3) @(negedge clk);
      push(1, -1, "R9"); push(2, DLY, "R9"); push(3, 1, "R4");
      en_ok = 1'b1;
      do @(negedge clk); while (!sample_start);
      sample_done = 1'b1;
      @(negedge clk);
      sample_done = 1'b0;
      chk("R9 resample after enable", n_samp, 2);

      // asynchronous supply loss mid-ramp
      repeat (5) @(negedge clk);
      push(0, -1, "R1"); push(1, -1, "R9"); push(2, DLY, "R9"); push(3, -1, "R4");
      #2 supply_ok = 1'b0;
      #1;
      chk("R1 async state", int'(state_o), 0);
      chk("R1 async sw_en", int'(sw_en), 0);
      chk("R1 async ref", int'(ref_code), 0);
      @(negedge clk);
      supply_ok = 1'b1;
      do @(negedge clk); while (!sample_start);
      sample_done = 1'b1;
      @(negedge clk);
      sample_done = 1'b0;
      chk("R9 resample after supply loss", n_samp, 3);
      repeat (5) @(negedge clk);
      chk("R5 scoreboard drained", q.size(), 0);
      finish_run();
   end
endmodule